// File: doc/BRIEF.md
# Guest Interrupt Exit Controller

This block runs beside a core that executes guest code. On every clock it looks at the pending interrupt sources, the guest's own masking state and a set of control bits from the hypervisor, and decides whether the guest should be forced out to the hypervisor. When it decides to exit, it raises an exit request with a reason code. It holds that request until the hypervisor side acknowledges it.

The block keeps the guest's interruptibility state itself. This state has two parts: a one-instruction block on maskable interrupts after a stack-segment load, and a block on non-maskable interrupts (NMIs) that lasts until an interrupt-return strobe. Guest writes to the task-priority register land in a shadow copy. A write that leaves the shadow below a programmable threshold schedules an exit. Control bits can force external interrupts to exit no matter what the guest's enable flag says, and can request an exit as soon as the guest opens its interrupt window.

Top module: `irqx_ctl`

## Requirements
- R1: With `ctl_ext_exit`=1, an `ext_irq_req` that is not stack-segment blocked raises `exit_req` with reason 1 on the next edge, whatever the value of `ie_flag`. With `ctl_ext_exit`=0, an external request never causes an exit.
- R2: With `ctl_win_exit`=1, `ie_flag`=1 and no stack-segment block, `exit_req` rises with reason 7 on the next edge. With `ie_flag`=0 or `ctl_win_exit`=0, no window exit is raised.
- R3: A `prio_wr_en` pulse stores `prio_wr_data` in the task-priority shadow, and `prio_shadow` shows the value from the next edge onward.
- R4: A shadow write whose value is unsigned-less-than `prio_thresh` raises `exit_req` with reason 43 one edge after the write edge. A write that is greater than or equal to the threshold raises no exit.
- R5: A retiring instruction (`insn_retire`=1) that has `ss_load`=1 sets `ss_block`. Exactly one later retiring instruction without `ss_load` clears it. While `ss_block` is set, external-interrupt and window exits are held off.
- R6: An `nmi_req` pulse becomes pending. A pending NMI with `nmi_block`=0 raises an exit with reason 0 one edge after the pulse and sets `nmi_block`. A later NMI stays pending until `iret_strobe` clears `nmi_block`, and then it exits.
- R7: When causes coincide, the NMI exit (reason 0) wins over the external exit (reason 1), which wins over the window exit (reason 7), which wins over the priority exit (reason 43). A cause that loses and is still pending exits after the winner is acknowledged.
- R8: `exit_req` and `exit_reason` stay stable until `exit_ack`. The acknowledge edge drops `exit_req` for at least one cycle, even if a cause is still present.
- R9: While `guest_mode`=0 no new exit is raised. Pending causes are kept and exit once `guest_mode` returns to 1.
- R10: After reset `exit_req`, `exit_reason`, `ss_block`, `nmi_block` and `prio_shadow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| guest_mode | input | 1 | Core is running guest code |
| ie_flag | input | 1 | Guest interrupt-enable flag |
| ctl_ext_exit | input | 1 | External interrupts force an exit |
| ctl_win_exit | input | 1 | Exit when the guest's interrupt window opens |
| ext_irq_req | input | 1 | External interrupt request (level) |
| nmi_req | input | 1 | NMI request pulse |
| insn_retire | input | 1 | A guest instruction retires this cycle |
| ss_load | input | 1 | The retiring instruction loaded the stack segment |
| iret_strobe | input | 1 | Interrupt return executed; ends NMI blocking |
| prio_wr_en | input | 1 | Guest task-priority write |
| prio_wr_data | input | PRIO_W | Value written to the task-priority shadow |
| prio_thresh | input | PRIO_W | Threshold for the priority-lowering exit |
| exit_ack | input | 1 | Acknowledge of the held exit |
| exit_req | output | 1 | Exit request |
| exit_reason | output | 6 | Reason code: 0 NMI, 1 external, 7 window, 43 priority |
| prio_shadow | output | PRIO_W | Task-priority shadow value |
| ss_block | output | 1 | Stack-segment interrupt block active |
| nmi_block | output | 1 | NMI blocking active |

## Verification
The bench builds the block with its default parameters: `PRIO_W`=4, with stack-segment tracking and the priority exit both enabled. With a 4-bit shadow, every pair of written value and threshold fits in 256 cases, so the bench sweeps the full less-than boundary of the priority exit. It also sweeps all 32 combinations of the NMI, external request, enable flag and the two control bits, and compares the expected winner arithmetically against the reason code. Directed sequences cover the one-instruction stack-segment block, NMI nesting across an interrupt return, holding the reason across changing inputs, and deferral outside guest mode.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
   localparam int RSN_W = 6;

   typedef enum logic [RSN_W-1:0] {
      RSN_NMI  = 6'd0,
      RSN_EXT  = 6'd1,
      RSN_WIN  = 6'd7,
      RSN_PRIO = 6'd43
   } rsn_e;

   typedef struct packed {
      logic nmi;
      logic ext;
      logic win;
      logic prio;
   } cause_t;
endpackage

// File: rtl/irqx_intr_state.sv
module irqx_intr_state #(
   parameter bit SS_TRACK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic insn_retire,
   input  logic ss_load,
   input  logic nmi_req,
   input  logic nmi_take,
   input  logic iret_strobe,
   output logic ss_block,
   output logic nmi_block,
   output logic nmi_pend
);
   generate
      if (SS_TRACK) begin : g_ss
         logic ss_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ss_q <= 1'b0;
            else if (insn_retire)
               ss_q <= ss_load;
         end
         assign ss_block = ss_q;

         AST_SS_ONE_INSN: assert property (@(posedge clk) disable iff (!rst_n)
            (ss_q && insn_retire && !ss_load) |=> !ss_q); // R5
         AST_SS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (ss_q && !insn_retire) |=> ss_q); // R5
      end else begin : g_no_ss
         assign ss_block = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_pend  <= 1'b0;
         nmi_block <= 1'b0;
      end else begin
         nmi_pend <= (nmi_pend & ~nmi_take) | nmi_req;
         if (nmi_take)
            nmi_block <= 1'b1;
         else if (iret_strobe)
            nmi_block <= 1'b0;
      end
   end

   AST_NMI_BLOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_take |=> nmi_block); // R6
endmodule

// File: rtl/irqx_prio_shadow.sv
module irqx_prio_shadow #(
   parameter int PRIO_W    = 4,
   parameter bit PRIO_EXIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PRIO_W-1:0] wr_data,
   input  logic [PRIO_W-1:0] thresh,
   input  logic              prio_take,
   output logic [PRIO_W-1:0] shadow,
   output logic              prio_pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow <= '0;
      else if (wr_en)
         shadow <= wr_data;
   end

   generate
      if (PRIO_EXIT) begin : g_cmp
         logic lowered;
         logic pend_q;
         assign lowered = wr_en && (wr_data < thresh);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_q <= 1'b0;
            else if (lowered)
               pend_q <= 1'b1;
            else if (prio_take)
               pend_q <= 1'b0;
         end
         assign prio_pend = pend_q;

         AST_PRIO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_data < thresh)) |=> prio_pend); // R4
      end else begin : g_no_cmp
         assign prio_pend = 1'b0;
      end
   endgenerate

   AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (shadow == $past(wr_data))); // R3
endmodule

// File: rtl/irqx_exit_arb.sv
module irqx_exit_arb
   import irqx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             guest_mode,
   input  cause_t           cause,
   input  logic             exit_ack,
   output cause_t           grant,
   output logic             exit_req,
   output logic [RSN_W-1:0] exit_reason
);
   logic       req_q;
   rsn_e       rsn_q;
   rsn_e       rsn_nxt;

   always_comb begin
      grant   = '0;
      rsn_nxt = RSN_NMI;
      if (!req_q && guest_mode) begin
         if (cause.nmi) begin
            grant.nmi = 1'b1;
            rsn_nxt   = RSN_NMI;
         end else if (cause.ext) begin
            grant.ext = 1'b1;
            rsn_nxt   = RSN_EXT;
         end else if (cause.win) begin
            grant.win = 1'b1;
            rsn_nxt   = RSN_WIN;
         end else if (cause.prio) begin
            grant.prio = 1'b1;
            rsn_nxt    = RSN_PRIO;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         rsn_q <= RSN_NMI;
      end else if (req_q) begin
         if (exit_ack)
            req_q <= 1'b0;
      end else if (|grant) begin
         req_q <= 1'b1;
         rsn_q <= rsn_nxt;
      end
   end

   assign exit_req    = req_q;
   assign exit_reason = rsn_q;

   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !exit_ack) |=> (req_q && $stable(rsn_q))); // R8
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && exit_ack) |=> !req_q); // R8
   AST_NO_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
      (!guest_mode && !req_q) |=> !req_q); // R9
   AST_REASON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (exit_reason inside {6'd0, 6'd1, 6'd7, 6'd43})); // R7
endmodule

// File: rtl/irqx_ctl.sv
module irqx_ctl
   import irqx_pkg::*;
#(
   parameter int PRIO_W    = 4,
   parameter bit SS_TRACK  = 1'b1,
   parameter bit PRIO_EXIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              guest_mode,
   input  logic              ie_flag,
   input  logic              ctl_ext_exit,
   input  logic              ctl_win_exit,
   input  logic              ext_irq_req,
   input  logic              nmi_req,
   input  logic              insn_retire,
   input  logic              ss_load,
   input  logic              iret_strobe,
   input  logic              prio_wr_en,
   input  logic [PRIO_W-1:0] prio_wr_data,
   input  logic [PRIO_W-1:0] prio_thresh,
   input  logic              exit_ack,
   output logic              exit_req,
   output logic [RSN_W-1:0]  exit_reason,
   output logic [PRIO_W-1:0] prio_shadow,
   output logic              ss_block,
   output logic              nmi_block
);
   generate
      if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_w
         $error("irqx_ctl: PRIO_W must lie in 1..16");
      end
   endgenerate

   cause_t cause;
   cause_t grant;
   logic   nmi_pend;
   logic   prio_pend;

   irqx_intr_state #(.SS_TRACK(SS_TRACK)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_retire(insn_retire),
      .ss_load    (ss_load),
      .nmi_req    (nmi_req),
      .nmi_take   (grant.nmi),
      .iret_strobe(iret_strobe),
      .ss_block   (ss_block),
      .nmi_block  (nmi_block),
      .nmi_pend   (nmi_pend)
   );

   irqx_prio_shadow #(.PRIO_W(PRIO_W), .PRIO_EXIT(PRIO_EXIT)) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (prio_wr_en),
      .wr_data  (prio_wr_data),
      .thresh   (prio_thresh),
      .prio_take(grant.prio),
      .shadow   (prio_shadow),
      .prio_pend(prio_pend)
   );

   always_comb begin
      cause.nmi  = nmi_pend & ~nmi_block;
      cause.ext  = ctl_ext_exit & ext_irq_req & ~ss_block;
      cause.win  = ctl_win_exit & ie_flag & ~ss_block;
      cause.prio = prio_pend;
   end

   irqx_exit_arb u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .guest_mode (guest_mode),
      .cause      (cause),
      .exit_ack   (exit_ack),
      .grant      (grant),
      .exit_req   (exit_req),
      .exit_reason(exit_reason)
   );

   AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      grant.nmi |-> !nmi_block); // R6
   AST_SS_GATES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_block && !nmi_pend && !prio_pend && !exit_req) |=> !exit_req); // R5
endmodule

// File: tb/test_irqx_ctl.sv
`timescale 1ns/1ps
module test_irqx_ctl;
   localparam int PW = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic guest_mode, ie_flag, ctl_ext_exit, ctl_win_exit, ext_irq_req, nmi_req;
   logic insn_retire, ss_load, iret_strobe, prio_wr_en, exit_ack;
   logic [PW-1:0] prio_wr_data, prio_thresh;
   logic exit_req, ss_block, nmi_block;
   logic [5:0] exit_reason;
   logic [PW-1:0] prio_shadow;

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irqx_ctl #(.PRIO_W(PW)) i_irqx_ctl (
      .clk(clk), .rst_n(rst_n), .guest_mode(guest_mode), .ie_flag(ie_flag),
      .ctl_ext_exit(ctl_ext_exit), .ctl_win_exit(ctl_win_exit),
      .ext_irq_req(ext_irq_req), .nmi_req(nmi_req), .insn_retire(insn_retire),
      .ss_load(ss_load), .iret_strobe(iret_strobe), .prio_wr_en(prio_wr_en),
      .prio_wr_data(prio_wr_data), .prio_thresh(prio_thresh), .exit_ack(exit_ack),
      .exit_req(exit_req), .exit_reason(exit_reason), .prio_shadow(prio_shadow),
      .ss_block(ss_block), .nmi_block(nmi_block)
   );

   task automatic chk(input string rq, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic quiet();
      ie_flag = 0; ctl_ext_exit = 0; ctl_win_exit = 0; ext_irq_req = 0;
      nmi_req = 0; insn_retire = 0; ss_load = 0; iret_strobe = 0;
      prio_wr_en = 0; exit_ack = 0;
   endtask

   task automatic ack_clear();
      quiet();
      exit_ack = 1; cyc();
      exit_ack = 0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      rst_n = 0; guest_mode = 1; prio_wr_data = '0; prio_thresh = '0;
      quiet();
      cyc(3);
      // R10 reset state
      chk("R10 exit_req", exit_req, 0);
      chk("R10 reason", exit_reason, 0);
      chk("R10 ss_block", ss_block, 0);
      chk("R10 nmi_block", nmi_block, 0);
      chk("R10 shadow", prio_shadow, 0);
      rst_n = 1; cyc(2);

      // R1 R2 R6 R7: sweep of nmi/ctl_ext/ctl_win/ie/ext
      for (int idx = 0; idx < 32; idx++) begin
         int exp_r;
         bit n, ce, cw, ie, ex;
         n = idx[0]; ce = idx[1]; cw = idx[2]; ie = idx[3]; ex = idx[4];
         exp_r = n ? 0 : (ce && ex) ? 1 : (cw && ie) ? 7 : -1;
         quiet(); nmi_req = n; cyc();
         nmi_req = 0; ctl_ext_exit = ce; ctl_win_exit = cw; ie_flag = ie; ext_irq_req = ex;
         cyc();
         chk("R7 sweep exit_req", exit_req, exp_r >= 0);
         if (exp_r >= 0) chk("R7 sweep reason", exit_reason, exp_r);
         ack_clear(); cyc();
         chk("R6 nmi_block after take", nmi_block, n);
         iret_strobe = 1; cyc(); iret_strobe = 0; cyc();
         chk("R6 nmi_block after iret", nmi_block, 0);
         chk("R8 idle after ack", exit_req, 0);
      end

      // R1 external with ie=0, and ctl off
      quiet(); ctl_ext_exit = 1; ext_irq_req = 1; ie_flag = 0; cyc();
      chk("R1 ext ie=0 exit", exit_req, 1);
      chk("R1 ext reason", exit_reason, 1);
      ack_clear(); cyc();
      ext_irq_req = 1; cyc(3);
      chk("R1 ext with ctl off", exit_req, 0);
      quiet(); cyc();

      // R2 window closed
      ctl_win_exit = 1; ie_flag = 0; cyc(3);
      chk("R2 window closed", exit_req, 0);
      ie_flag = 1; cyc();
      chk("R2 window opens", exit_req, 1);
      chk("R2 window reason", exit_reason, 7);
      ack_clear(); cyc();

      // R5 stack-segment block lasts one instruction
      insn_retire = 1; ss_load = 1; cyc();
      insn_retire = 0; ss_load = 0; ctl_ext_exit = 1; ext_irq_req = 1; cyc();
      chk("R5 ss_block set", ss_block, 1);
      chk("R5 ext held off", exit_req, 0);
      cyc(2);
      chk("R5 still blocked w/o retire", exit_req, 0);
      insn_retire = 1; cyc();
      insn_retire = 0;
      chk("R5 cleared after one insn", ss_block, 0);
      chk("R5 no exit on clear edge", exit_req, 0);
      cyc();
      chk("R5 ext after block", exit_req, 1);
      chk("R5 reason", exit_reason, 1);

      // R8 hold across changing inputs, drop on ack even with cause present
      ctl_ext_exit = 0; ext_irq_req = 0; ctl_win_exit = 1; ie_flag = 1; cyc(3);
      chk("R8 held", exit_req, 1);
      chk("R8 reason stable", exit_reason, 1);
      exit_ack = 1; cyc(); exit_ack = 0;
      chk("R8 drop on ack", exit_req, 0);
      cyc();
      chk("R8 re-raise", exit_req, 1);
      chk("R8 new reason", exit_reason, 7);
      ack_clear(); cyc();

      // R6 second NMI waits for iret
      nmi_req = 1; cyc(); nmi_req = 0; cyc();
      chk("R6 first nmi", exit_req, 1);
      chk("R6 reason", exit_reason, 0);
      ack_clear();
      nmi_req = 1; cyc(); nmi_req = 0; cyc(3);
      chk("R6 second nmi held", exit_req, 0);
      chk("R6 blocked", nmi_block, 1);
      iret_strobe = 1; cyc(); iret_strobe = 0;
      chk("R6 iret edge", exit_req, 0);
      cyc();
      chk("R6 second nmi exits", exit_req, 1);
      chk("R6 second reason", exit_reason, 0);
      ack_clear(); iret_strobe = 1; cyc(); iret_strobe = 0; cyc();

      // R9 outside guest, with R7 window over priority
      guest_mode = 0;
      prio_thresh = 4'd9; prio_wr_data = 4'd2; prio_wr_en = 1; cyc(); prio_wr_en = 0;
      ctl_win_exit = 1; ie_flag = 1; cyc(3);
      chk("R9 no exit outside guest", exit_req, 0);
      guest_mode = 1; cyc();
      chk("R9 exit on return", exit_req, 1);
      chk("R7 window beats priority", exit_reason, 7);
      ack_clear(); cyc();
      chk("R7 priority after ack", exit_req, 1);
      chk("R7 priority reason", exit_reason, 43);
      ack_clear(); cyc();

      // R3 R4 exhaustive value/threshold sweep
      for (int t = 0; t < 16; t++) begin
         for (int d = 0; d < 16; d++) begin
            quiet(); prio_thresh = t[PW-1:0]; prio_wr_data = d[PW-1:0]; prio_wr_en = 1;
            cyc(); prio_wr_en = 0;
            chk("R3 shadow value", prio_shadow, d);
            chk("R4 not before capture", exit_req, 0);
            cyc();
            chk("R4 threshold exit", exit_req, (d < t) ? 1 : 0);
            if (d < t) chk("R4 reason", exit_reason, 43);
            ack_clear(); cyc();
         end
      end

      summary();
   end
endmodule